// File: doc/BRIEF.md
# Cycle-Stealing DMA Controller

This block is a single-channel direct memory access engine. The processor configures it through a four-slot register interface. It sets a direction bit, picks one of several devices, loads a start memory address and a byte count, and then issues a start command. From that point the engine moves data between the chosen device and memory, and the processor does not touch the data.

The engine takes the system bus for one cycle per byte. When the selected device signals that it is ready, the engine raises a bus request and waits for the grant. It then performs a single memory access, acknowledges the device in the same cycle, and drops the request. In between bytes the bus goes back to the processor. After the last byte the engine raises an interrupt. The interrupt stays high until the processor clears it with a command write.

Top module: `cyc_dma`

Register slots (selected by `cfgSel`):

| Slot | Write | Read |
|------|-------|------|
| 0 | Mode: bit 0 is the direction (0 = device to memory, 1 = memory to device); bits [DEV_W:1] are the device number | The mode as written |
| 1 | Start address | Current address |
| 2 | Byte count | Remaining count |
| 3 | Command: bit 0 = start, bit 1 = clear interrupt | Status: bit 0 = interrupt, bit 1 = busy |

## Requirements
- R1: After reset, `busReq`, `memEn`, `devAck` and `irq` are low, and status (slot 3) reads 0.
- R2: When the direction bit is 0, the byte on `devRdata` is written to memory on each transfer (`memWe` high). Successive bytes go to successive addresses, beginning at the start address.
- R3: When the direction bit is 1, memory is read on each transfer (`memWe` low), and `memRdata` is passed to `devWdata` while the device is acknowledged.
- R4: `busReq` rises only after the selected device has asserted its `devReq` bit. `memEn` is high only while `busGnt` is high. `busReq` is low in the cycle after every access, so each byte uses its own bus tenure.
- R5: After each transfer, the address read from slot 1 is one higher and the count read from slot 2 is one lower.
- R6: Only the `devAck` bit of the device number in bits [DEV_W:1] of the mode is ever asserted. A `devReq` from any other device starts nothing.
- R7: `irq` rises at the end of the last byte and busy (status bit 1) falls at the same time. `irq` stays high until a slot 3 write with bit 1 set.
- R8: A start with a count of 0 sets `irq` on the next edge, leaves busy low, and never raises `busReq`.
- R9: While busy, writes to slots 0, 1 and 2 are ignored, and so are start commands. A clear of the interrupt still takes effect.
- R10: Busy reads 1 from the start edge until the last byte completes. This holds while the engine waits for the device and while it waits for the grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Register write strobe |
| cfgSel | input | 2 | Register slot select |
| cfgWdata | input | REG_W | Register write data |
| regRdata | output | REG_W | Read data of the selected slot (combinational) |
| busReq | output | 1 | Bus request to the arbiter |
| busGnt | input | 1 | Bus grant from the arbiter |
| memEn | output | 1 | Memory access strobe |
| memWe | output | 1 | Memory write enable (valid while `memEn` is high) |
| memAddr | output | ADDR_W | Memory address |
| memWdata | output | 8 | Memory write data |
| memRdata | input | 8 | Memory read data (same cycle) |
| devReq | input | DEV_N | Device ready/request lines |
| devAck | output | DEV_N | Device acknowledge, one-hot |
| devRdata | input | 8 | Data from the device |
| devWdata | output | 8 | Data to the device |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest state to reach from the ports is a live transfer that is parked while busy. In that state the setup writes must bounce, the bus request must be held without a grant, and no memory access may occur. The bench reaches it by starting a transfer whose selected device is still silent. It tries overwrites in that state, then turns the device on while the arbiter withholds the grant for several cycles. Only then does it release the grant. It also keeps an unselected device requesting during a memory-to-device run, to show that the unselected device's request is ignored.

// File: rtl/cyc_dma_pkg.sv
package cyc_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAITDEV = 2'd1,
    ST_REQ     = 2'd2,
    ST_XFER    = 2'd3
  } dmaState_t;

  typedef struct packed {
    logic ldMode;
    logic ldAddr;
    logic ldCnt;
    logic step;
    logic xfer;
  } dmaStrobe_t;

  localparam logic [1:0] SEL_MODE = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_CMD  = 2'd3;

endpackage

// File: rtl/cyc_dma_ctrl.sv
module cyc_dma_ctrl
  import cyc_dma_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [1:0]       cfgSel,
  input  logic [REG_W-1:0] cfgWdata,
  input  logic             busGnt,
  input  logic             devReady,
  input  logic             cntZero,
  input  logic             cntOne,
  output dmaStrobe_t       st,
  output logic             busReq,
  output logic             busy,
  output logic             irq
);

  dmaState_t state;
  logic cmdWr, startCmd, clrCmd;

  assign busy     = (state != ST_IDLE);
  assign cmdWr    = cfgWe && (cfgSel == SEL_CMD);
  assign startCmd = cmdWr && cfgWdata[0] && !busy;
  assign clrCmd   = cmdWr && cfgWdata[1];
  assign busReq   = (state == ST_REQ) || (state == ST_XFER);

  always_comb begin
    st        = '0;
    st.ldMode = cfgWe && (cfgSel == SEL_MODE) && !busy;
    st.ldAddr = cfgWe && (cfgSel == SEL_ADDR) && !busy;
    st.ldCnt  = cfgWe && (cfgSel == SEL_CNT)  && !busy;
    st.xfer   = (state == ST_XFER);
    st.step   = (state == ST_XFER);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      irq   <= 1'b0;
    end else begin
      if (clrCmd) irq <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (startCmd) begin
            if (cntZero) irq   <= 1'b1;
            else         state <= ST_WAITDEV;
          end
        end
        ST_WAITDEV: if (devReady) state <= ST_REQ;
        ST_REQ:     if (busGnt)   state <= ST_XFER;
        ST_XFER: begin
          if (cntOne) begin
            state <= ST_IDLE;
            irq   <= 1'b1;
          end else begin
            state <= ST_WAITDEV;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cyc_dma_dp.sv
module cyc_dma_dp
  import cyc_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DEV_N  = 4,
  parameter int REG_W  = 16,
  localparam int DEV_W = (DEV_N > 1) ? $clog2(DEV_N) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobe_t        st,
  input  logic [1:0]        cfgSel,
  input  logic [REG_W-1:0]  cfgWdata,
  input  logic [1:0]        statusBits,
  input  logic [DEV_N-1:0]  devReq,
  input  logic [7:0]        devRdata,
  input  logic [7:0]        memRdata,
  output logic [REG_W-1:0]  regRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [7:0]        memWdata,
  output logic [DEV_N-1:0]  devAck,
  output logic [7:0]        devWdata,
  output logic              devReady,
  output logic              cntZero,
  output logic              cntOne
);

  logic              dirQ;
  logic [DEV_W-1:0]  devQ;
  logic [ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ  <= 1'b0;
      devQ  <= '0;
      addrQ <= '0;
      cntQ  <= '0;
    end else begin
      if (st.ldMode) begin
        dirQ <= cfgWdata[0];
        devQ <= cfgWdata[DEV_W:1];
      end
      if (st.ldAddr) addrQ <= cfgWdata[ADDR_W-1:0];
      else if (st.step) addrQ <= addrQ + 1'b1;
      if (st.ldCnt) cntQ <= cfgWdata[CNT_W-1:0];
      else if (st.step) cntQ <= cntQ - 1'b1;
    end
  end

  assign cntZero  = (cntQ == '0);
  assign cntOne   = (cntQ == CNT_W'(1));
  assign devReady = devReq[devQ];
  assign memAddr  = addrQ;
  assign memWe    = st.xfer && !dirQ;
  assign memWdata = devRdata;
  assign devWdata = memRdata;

  for (genvar i = 0; i < DEV_N; i++) begin : g_ack
    assign devAck[i] = st.xfer && (devQ == DEV_W'(i));
  end

  always_comb begin
    unique case (cfgSel)
      SEL_MODE: regRdata = REG_W'({devQ, dirQ});
      SEL_ADDR: regRdata = REG_W'(addrQ);
      SEL_CNT:  regRdata = REG_W'(cntQ);
      default:  regRdata = REG_W'(statusBits);
    endcase
  end

endmodule

// File: rtl/cyc_dma.sv
module cyc_dma
  import cyc_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DEV_N  = 4,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [REG_W-1:0]  cfgWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic              busReq,
  input  logic              busGnt,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata,
  input  logic [DEV_N-1:0]  devReq,
  output logic [DEV_N-1:0]  devAck,
  input  logic [7:0]        devRdata,
  output logic [7:0]        devWdata,
  output logic              irq
);

  dmaStrobe_t st;
  logic busy, devReady, cntZero, cntOne;

  cyc_dma_ctrl #(.REG_W(REG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgWdata(cfgWdata), .busGnt(busGnt), .devReady(devReady),
    .cntZero(cntZero), .cntOne(cntOne), .st(st), .busReq(busReq),
    .busy(busy), .irq(irq)
  );

  cyc_dma_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEV_N(DEV_N), .REG_W(REG_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .statusBits({busy, irq}), .devReq(devReq), .devRdata(devRdata),
    .memRdata(memRdata), .regRdata(regRdata), .memAddr(memAddr),
    .memWe(memWe), .memWdata(memWdata), .devAck(devAck),
    .devWdata(devWdata), .devReady(devReady), .cntZero(cntZero),
    .cntOne(cntOne)
  );

  assign memEn = st.xfer;

endmodule

// File: rtl/cyc_dma_chk.sv
module cyc_dma_chk #(
  parameter int ADDR_W = 16,
  parameter int REG_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWe,
  input logic [1:0]        cfgSel,
  input logic [REG_W-1:0]  cfgWdata,
  input logic              busReq,
  input logic              busGnt,
  input logic              memEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic              busy,
  input logic              irq
);

  // R4
  mem_needs_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    memEn |-> busGnt);

  // R4
  bus_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    memEn |=> !busReq);

  // R8
  idle_no_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !busReq);

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    memEn |=> (memAddr == $past(memAddr) + 1'b1));

  // R9
  busy_addr_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !memEn && cfgWe && cfgSel == 2'd1) |=> $stable(memAddr));

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(cfgWe && cfgSel == 2'd3 && cfgWdata[1])) |=> irq);

endmodule

bind cyc_dma cyc_dma_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel),
  .cfgWdata(cfgWdata), .busReq(busReq), .busGnt(busGnt), .memEn(memEn),
  .memAddr(memAddr), .busy(busy), .irq(irq)
);

// File: tb/sim_cyc_dma.sv
module sim_cyc_dma;
  localparam int CLK_PERIOD = 10;
  localparam int DEV_N = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgSel = 2'd0;
  logic [15:0] cfgWdata = '0;
  logic [15:0] regRdata;
  logic busReq, busGnt, memEn, memWe, irq;
  logic [15:0] memAddr;
  logic [7:0] memWdata, memRdata, devRdata, devWdata;
  logic [DEV_N-1:0] devReq, devAck, devOn, ackQ;
  logic cpuHold = 1'b0;

  logic [7:0] mem [256];
  logic tbWe = 1'b0;
  logic [7:0] tbAddr = '0, tbData = '0;
  logic clrMon = 1'b0;
  int reqRises, otherAcks, memWrites, datN, capN;
  logic [7:0] cap [16];
  logic busReqQ;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cyc_dma u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .regRdata(regRdata), .busReq(busReq), .busGnt(busGnt), .memEn(memEn),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .devReq(devReq), .devAck(devAck), .devRdata(devRdata), .devWdata(devWdata),
    .irq(irq)
  );

  // Arbiter, memory and device models
  always @(posedge clk) busGnt <= rstN && busReq && !cpuHold;
  always @(posedge clk) ackQ <= devAck;
  assign devReq   = devOn & ~ackQ;
  assign memRdata = mem[memAddr[7:0]];
  assign devRdata = 8'h30 + 8'(datN);

  always @(posedge clk) begin
    if (tbWe) mem[tbAddr] <= tbData;
    else if (memEn && memWe) mem[memAddr[7:0]] <= memWdata;
  end

  logic [DEV_N-1:0] selMask;
  always @(posedge clk) begin
    busReqQ <= busReq;
    if (clrMon) begin
      reqRises <= 0; otherAcks <= 0; memWrites <= 0; datN <= 0; capN <= 0;
    end else begin
      if (busReq && !busReqQ) reqRises <= reqRises + 1;
      if ((devAck & ~selMask) != '0) otherAcks <= otherAcks + 1;
      if (memEn && memWe) memWrites <= memWrites + 1;
      if (devAck != '0) begin
        datN <= datN + 1;
        cap[capN[3:0]] <= devWdata;
        capN <= capN + 1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output int v);
    @(negedge clk);
    cfgSel = sel;
    #1 v = int'(regRdata);
  endtask

  task automatic memPut(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    tbWe = 1'b1; tbAddr = a; tbData = d;
    @(negedge clk);
    tbWe = 1'b0;
  endtask

  task automatic monClear(input logic [DEV_N-1:0] mask);
    @(negedge clk);
    selMask = mask; clrMon = 1'b1;
    @(negedge clk);
    clrMon = 1'b0;
  endtask

  task automatic waitIrq(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (irq) begin ok = 1'b1; break; end
    end
  endtask

  task automatic t_reset;
    int v;
    chk("R1 busReq", int'(busReq), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 devAck", int'(devAck), 0);
    chk("R1 memEn", int'(memEn), 0);
    rd(2'd3, v); chk("R1 status", v, 0);
  endtask

  task automatic t_dev2mem;
    int v; bit ok;
    memPut(8'h15, 8'hEE);
    monClear(4'b0010);
    wr(2'd0, 16'h0002);          // dir 0, device 1
    wr(2'd1, 16'h0010);
    wr(2'd2, 16'd5);
    devOn = 4'b0010;
    wr(2'd3, 16'h0001);
    waitIrq(ok);
    chk("R7 irq after last byte", int'(ok), 1);
    for (int i = 0; i < 5; i++) chk("R2 dev->mem byte", int'(mem[8'h10 + i]), 8'h30 + i);
    chk("R2 byte past end untouched", int'(mem[8'h15]), 8'hEE);
    rd(2'd1, v); chk("R5 final address", v, 16'h0015);
    rd(2'd2, v); chk("R5 final count", v, 0);
    rd(2'd3, v); chk("R7 status irq set busy clear", v, 1);
    chk("R4 one bus tenure per byte", reqRises, 5);
    chk("R2 memory writes", memWrites, 5);
    devOn = '0;
    repeat (5) @(negedge clk);
    chk("R7 irq held", int'(irq), 1);
    wr(2'd3, 16'h0002);
    chk("R7 irq cleared", int'(irq), 0);
  endtask

  task automatic t_mem2dev;
    bit ok;
    for (int i = 0; i < 4; i++) memPut(8'h40 + 8'(i), 8'hC0 + 8'(i * 3));
    monClear(4'b0100);
    wr(2'd0, 16'h0005);          // dir 1, device 2
    wr(2'd1, 16'h0040);
    wr(2'd2, 16'd4);
    devOn = 4'b0101;             // device 0 requests too but is not selected
    wr(2'd3, 16'h0001);
    waitIrq(ok);
    chk("R7 irq mem->dev", int'(ok), 1);
    chk("R3 bytes delivered", capN, 4);
    for (int i = 0; i < 4; i++) chk("R3 mem->dev data", int'(cap[i]), 8'hC0 + i * 3);
    chk("R3 no memory writes", memWrites, 0);
    chk("R6 unselected device never acked", otherAcks, 0);
    devOn = '0;
    wr(2'd3, 16'h0002);
  endtask

  task automatic t_busy;
    int v; bit ok;
    monClear(4'b1000);
    wr(2'd0, 16'h0006);          // dir 0, device 3
    wr(2'd1, 16'h0080);
    wr(2'd2, 16'd3);
    wr(2'd3, 16'h0001);
    repeat (4) @(negedge clk);
    rd(2'd3, v); chk("R10 busy while device silent", v, 2);
    chk("R4 no request before device ready", int'(busReq), 0);
    wr(2'd1, 16'h0099);
    wr(2'd2, 16'd7);
    wr(2'd0, 16'h0003);
    wr(2'd3, 16'h0001);
    rd(2'd1, v); chk("R9 address write ignored", v, 16'h0080);
    rd(2'd2, v); chk("R9 count write ignored", v, 3);
    rd(2'd0, v); chk("R9 mode write ignored", v, 6);
    cpuHold = 1'b1;
    devOn = 4'b1000;
    repeat (8) @(negedge clk);
    chk("R4 request held while grant withheld", int'(busReq), 1);
    chk("R4 no access without grant", capN, 0);
    rd(2'd3, v); chk("R10 busy while waiting for grant", v, 2);
    cpuHold = 1'b0;
    waitIrq(ok);
    chk("R7 irq after held run", int'(ok), 1);
    for (int i = 0; i < 3; i++) chk("R2 held run data", int'(mem[8'h80 + i]), 8'h30 + i);
    devOn = '0;
    wr(2'd3, 16'h0002);
  endtask

  task automatic t_zero;
    int v;
    monClear(4'b0010);
    wr(2'd0, 16'h0002);
    wr(2'd2, 16'd0);
    devOn = 4'b0010;
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = 2'd3; cfgWdata = 16'h0001;
    @(negedge clk);
    cfgWe = 1'b0;
    chk("R8 irq one edge after zero start", int'(irq), 1);
    rd(2'd3, v); chk("R8 not busy", v, 1);
    repeat (5) @(negedge clk);
    chk("R8 bus never requested", reqRises, 0);
    devOn = '0;
    wr(2'd3, 16'h0002);
  endtask

  initial begin
    devOn = '0;
    selMask = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_dev2mem();
    t_mem2dev();
    t_busy();
    t_zero();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule